// File: doc/BRIEF.md
# Mid-Bit Validating Serial Receiver with Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It watches the serial line only on cycles where a 16x oversampling enable is high. A falling edge on the line starts a counter, and the line is looked at again eight enables later, at the middle of the start bit. If the line has gone high by then, the edge is treated as noise and the receiver goes back to waiting. If the line is still low, the receiver samples each data bit, an optional even-parity bit and the stop bit at the centre of its bit period, 16 enables apart. The data bits arrive least significant bit first.

Each finished character goes into a 16-entry queue together with three error tags. The head entry is always shown on the outputs. Because the tags travel with their byte, the error bits always describe the byte at the head. A host pop removes the head. A data-ready interrupt is raised either whenever a character is waiting, or only once the queue holds at least a selected number of entries. The interrupt is masked by an enable input.

Top module: `uart_rx_mid`

## Requirements
- R1: A high-to-low change of `rxd`, seen between two successive `tick16` samples, starts a character. The data bits are sampled at their centres, least significant bit first, and appear unchanged on `rx_data`.
- R2: If `rxd` is high at the eighth `tick16` after the detected falling edge, the receiver returns to idle and stores no character.
- R3: If the stop bit is sampled low, framing tag `rx_err[1]` is set for that byte.
- R4: If the data bits are all zero, the stop bit is low, and any enabled parity bit is also low, break tag `rx_err[2]` is set together with `rx_err[1]`.
- R5: When `par_en` is 1, a ninth bit follows the data. `rx_err[0]` is set when the data and parity bits together hold an odd number of ones (even parity).
- R6: The queue holds 16 characters in arrival order. `data_ready` is 1 exactly when the queue is not empty. While the queue is empty, `rx_data` and `rx_err` read 0.
- R7: A `pop` while `data_ready` is 1 advances the head. On the next cycle, `rx_data` and `rx_err` show the next byte and that byte's own tags.
- R8: A character that completes while the queue is full, with no pop in the same cycle, is discarded and sets `overrun`. `overrun` stays 1 until the next accepted pop clears it.
- R9: A character that completes in the same cycle as a pop of a full queue is accepted. The queue stays full, no overrun is flagged, and the order is kept.
- R10: `irq` is 0 while `irq_en` is 0. With `irq_en` at 1 and `per_char` at 1, `irq` equals `data_ready`. With `per_char` at 0, `irq` is 1 when the fill is at least the level picked by `trig_sel` (0: 1, 1: 4, 2: 8, 3: 14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x bit-rate sample enable |
| rxd | input | 1 | Serial input, idles high |
| par_en | input | 1 | Expect an even-parity bit after the data |
| pop | input | 1 | Remove the head character |
| irq_en | input | 1 | Data-ready interrupt enable |
| per_char | input | 1 | 1: interrupt on any waiting character; 0: use the trigger level |
| trig_sel | input | 2 | Trigger level select (1, 4, 8, 14 entries) |
| rx_data | output | 8 | Head character |
| rx_err | output | 3 | Head tags: [0] parity, [1] framing, [2] break |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | A character was dropped because the queue was full |
| irq | output | 1 | Data-ready interrupt |

## Verification
A character completing and a host pop can land on the same clock edge. This matters most when the queue is full, because the write and the read then share the slot being freed. The bench produces its own sample enables, so it knows which enable samples the stop bit. It fills the queue with 16 characters, then raises `pop` on exactly that enable of a 17th character. It judges the result by checking that `overrun` stays 0 and that draining returns bytes two to sixteen followed by the 17th, in order.

// File: rtl/uart_rx_mid.sv
module uart_rx_mid #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       par_en,
  input  logic       pop,
  input  logic       irq_en,
  input  logic       per_char,
  input  logic [1:0] trig_sel,
  output logic [7:0] rx_data,
  output logic [2:0] rx_err,
  output logic       data_ready,
  output logic       overrun,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [7:0]    shreg;
  logic          pbit, rx_last;
  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count, level;

  wire frame_done = tick16 && st == STOP && cnt == LAST;
  wire do_pop     = pop && count != '0;
  wire do_push    = frame_done && (count != FULL || do_pop);
  wire fe = ~rxd;
  wire br = ~rxd && shreg == 8'h00 && !(par_en && pbit);
  wire pe = par_en && ((^shreg) ^ pbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bitn <= '0; shreg <= '0; pbit <= 1'b0; rx_last <= 1'b1;
    end else if (tick16) begin
      rx_last <= rxd;
      case (st)
        IDLE:  if (rx_last && !rxd) begin st <= START; cnt <= '0; end
        START: if (cnt == MID) begin
                 if (rxd) st <= IDLE;
                 else begin st <= DATA; cnt <= '0; bitn <= '0; end
               end else cnt <= cnt + 1'b1;
        DATA:  if (cnt == LAST) begin
                 cnt <= '0;
                 if (bitn < 4'd8) shreg <= {rxd, shreg[7:1]};
                 else pbit <= rxd;
                 bitn <= bitn + 1'b1;
                 if ((bitn == 4'd7 && !par_en) || bitn == 4'd8) st <= STOP;
               end else cnt <= cnt + 1'b1;
        STOP:  if (cnt == LAST) st <= IDLE;
               else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= {br, fe, pe, shreg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (frame_done && !do_push) overrun <= 1'b1;
      else if (do_pop) overrun <= 1'b0;
    end
  end

  always_comb
    case (trig_sel)
      2'd0: level = (AW+1)'(1);
      2'd1: level = (AW+1)'(4);
      2'd2: level = (AW+1)'(8);
      default: level = (AW+1)'(14);
    endcase

  assign data_ready = count != '0;
  assign rx_data    = data_ready ? mem[rp][7:0]  : 8'h00;
  assign rx_err     = data_ready ? mem[rp][10:8] : 3'b000;
  assign irq        = irq_en && (per_char ? data_ready : count >= level);

  always_comb if (rst_n) a_r6_fill_bound: assert (count <= FULL);

  a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && st == START && cnt == MID && rxd) |=> st == IDLE);

  a_r7_pop_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && data_ready && !frame_done) |=> count == $past(count) - 1'b1);

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && count == FULL && !pop) |=> overrun && count == FULL);

  a_r9_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && count == FULL && pop) |=> !$changed(overrun) && count == FULL);

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/uart_rx_mid_test.sv
module uart_rx_mid_test;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1, par_en = 0, pop = 0;
  logic irq_en = 0, per_char = 1;
  logic [1:0] trig_sel = 0;
  logic [7:0] rx_data;
  logic [2:0] rx_err;
  logic data_ready, overrun, irq;
  int checks = 0, errors = 0;

  uart_rx_mid uut (.clk, .rst_n, .tick16, .rxd, .par_en, .pop, .irq_en, .per_char,
                   .trig_sel, .rx_data, .rx_err, .data_ready, .overrun, .irq);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tk(input logic p);
    @(negedge clk); tick16 = 1; pop = p;
    @(negedge clk); tick16 = 0; pop = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit pon, input bit pv, input bit sv, input int popt);
    int nb;
    nb = pon ? 11 : 10;
    rxd = 1;
    for (int i = 0; i < 4; i++) tk(0);
    for (int t = 0; t < nb * 16; t++) begin
      int b;
      b = t / 16;
      if (b == 0) rxd = 0;
      else if (b <= 8) rxd = d[b-1];
      else if (pon && b == 9) rxd = pv;
      else rxd = sv;
      tk(t == popt);
    end
    rxd = 1;
    tk(0); tk(0);
  endtask

  task automatic pop1;
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  task automatic drain;
    while (data_ready) pop1();
  endtask

  task automatic t_reset;
    check("R6 reset ready", data_ready, 0);
    check("R6 reset data", rx_data, 0);
    check("R6 reset err", rx_err, 0);
    check("R8 reset overrun", overrun, 0);
    check("R10 reset irq", irq, 0);
  endtask

  task automatic t_basic;
    send(8'hA5, 0, 0, 1, -1);
    send(8'h3C, 0, 0, 1, -1);
    check("R1 first byte", rx_data, 8'hA5);
    check("R1 clean tags", rx_err, 0);
    check("R6 ready", data_ready, 1);
    pop1();
    check("R7 second byte", rx_data, 8'h3C);
    pop1();
    check("R6 empty after pops", data_ready, 0);
  endtask

  task automatic t_false_start;
    rxd = 1; for (int i = 0; i < 4; i++) tk(0);
    rxd = 0; for (int i = 0; i < 4; i++) tk(0);
    rxd = 1; for (int i = 0; i < 200; i++) tk(0);
    check("R2 glitch stores nothing", data_ready, 0);
    send(8'h5A, 0, 0, 1, -1);
    check("R2 next frame intact", rx_data, 8'h5A);
    drain();
  endtask

  task automatic t_errors;
    send(8'h55, 0, 0, 0, -1);
    send(8'h00, 0, 0, 0, -1);
    send(8'h66, 0, 0, 1, -1);
    check("R3 framing data", rx_data, 8'h55);
    check("R3 framing tag", rx_err, 3'b010);
    pop1();
    check("R4 break tag", rx_err, 3'b110);
    pop1();
    check("R7 tags follow head", rx_err, 3'b000);
    check("R7 data follows head", rx_data, 8'h66);
    drain();
  endtask

  task automatic t_parity;
    par_en = 1;
    send(8'h07, 1, ^8'h07, 1, -1);
    send(8'h07, 1, ~^8'h07, 1, -1);
    check("R5 good parity data", rx_data, 8'h07);
    check("R5 good parity tag", rx_err, 0);
    pop1();
    check("R5 bad parity tag", rx_err, 3'b001);
    drain();
    par_en = 0;
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++) send(8'h20 + 8'(i), 0, 0, 1, -1);
    check("R8 no overrun at full", overrun, 0);
    send(8'h99, 0, 0, 1, -1);
    check("R8 overrun set", overrun, 1);
    check("R8 head kept", rx_data, 8'h20);
    pop1();
    check("R8 overrun cleared by pop", overrun, 0);
    for (int i = 1; i < 16; i++) begin
      check("R6 order", rx_data, 8'h20 + 8'(i));
      pop1();
    end
    check("R8 dropped byte absent", data_ready, 0);
  endtask

  task automatic t_collide;
    for (int i = 0; i < 16; i++) send(8'h10 + 8'(i), 0, 0, 1, -1);
    send(8'h77, 0, 0, 1, 152);
    check("R9 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) begin
      check("R9 order", rx_data, 8'h10 + 8'(i));
      pop1();
    end
    check("R9 last byte kept", rx_data, 8'h77);
    pop1();
    check("R9 empty", data_ready, 0);
  endtask

  task automatic t_irq;
    irq_en = 0; per_char = 1;
    send(8'h01, 0, 0, 1, -1);
    check("R10 masked", irq, 0);
    irq_en = 1; #1;
    check("R10 per char", irq, 1);
    drain(); #1;
    check("R10 per char empty", irq, 0);
    per_char = 0; trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send(8'h40, 0, 0, 1, -1);
    check("R10 below level 4", irq, 0);
    send(8'h41, 0, 0, 1, -1);
    check("R10 at level 4", irq, 1);
    trig_sel = 2'd2; #1;
    check("R10 below level 8", irq, 0);
    drain();
    trig_sel = 2'd3;
    for (int i = 0; i < 13; i++) send(8'h42, 0, 0, 1, -1);
    check("R10 below level 14", irq, 0);
    send(8'h43, 0, 0, 1, -1);
    check("R10 at level 14", irq, 1);
    drain();
    irq_en = 0; per_char = 1; trig_sel = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_false_start();
    t_errors();
    t_parity();
    t_overrun();
    t_collide();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule